// File: doc/BRIEF.md
# Packed Q15 Rounding Multiplier Unit

This execution unit takes two packed vectors of signed 16-bit elements and multiplies them lane by lane. Each lane returns a rounded, scaled upper part of its 32-bit product, which is the usual Q15 fixed-point multiply with round-to-nearest. A width select chooses whether 4, 8 or 16 lanes are active. A style flag decides what happens to result bits above the active width: the older style keeps the previous destination contents there, and the newer style clears them.

The unit also decodes two faults at issue. An alignment fault fires for a misaligned 128-bit memory source. An undefined-opcode fault fires for a newer-style 128-bit operation whose length bit is set. When either fault fires, no computed result is written, and the output carries the previous destination value unchanged.

There is one registered stage, controlled by a small state machine. `ST_IDLE` moves to `ST_DONE` on a clean issue, to `ST_FLT_UD` on an undefined-opcode issue and to `ST_FLT_GP` on an alignment-fault issue. Every state goes back to `ST_IDLE` when no issue is presented, and moves to one of the other three states when a new issue arrives.

Top module: `q15_rmul_unit`

## Requirements
- R1: For an active lane, let P be the signed 32-bit product of the two signed 16-bit inputs. The lane output is bits 16..1 of (P arithmetically shifted right by 14, plus 1).
- R2: Lane i uses bits 16*i+15..16*i of both sources. The width_sel encoding is: 2'b00 gives 4 lanes (64 bits), 2'b01 gives 8 lanes (128 bits), and 2'b10 or 2'b11 gives 16 lanes (256 bits). Lanes do not influence each other.
- R3: A lane with both inputs equal to -32768 produces 16'h8000, with no saturation, and its neighbours are unaffected.
- R4: With new_style=0, result bits above the active width equal the previous destination bits.
- R5: With new_style=1, result bits above the active width are zero.
- R6: A 128-bit issue with mem_src=1 and a nonzero mem_addr[3:0] raises fault_gp. The result then equals the previous destination.
- R7: A 128-bit issue with new_style=1 and len_bit=1 raises fault_ud. The result then equals the previous destination.
- R8: When both fault conditions hold, only fault_ud is raised. The two fault outputs are never high together.
- R9: A fault output is high only while res_valid is high. After a single issue it is high for exactly one cycle.
- R10: res_valid follows in_valid after exactly one clock edge. Reset drives res_valid, both fault outputs and res_out to zero.
- R11: No fault is raised in the following cases: a register source, an aligned address, the 64-bit or 256-bit width, or len_bit set in the older style.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| width_sel | input | 2 | Active width select |
| new_style | input | 1 | 1 clears upper result bits and enables the length check |
| mem_src | input | 1 | Second source comes from memory |
| mem_addr | input | 48 | Byte address of the memory source |
| len_bit | input | 1 | Encoding length bit |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector |
| dest_prev | input | 256 | Previous destination contents |
| res_out | output | 256 | Result vector |
| res_valid | output | 1 | Result strobe |
| fault_gp | output | 1 | Alignment fault pulse |
| fault_ud | output | 1 | Undefined-opcode fault pulse |

## Verification
The following properties are checked on every cycle:
- the one-cycle valid latency;
- that the fault pulses are exclusive and occur only together with res_valid;
- fault priority, and that a faulted result is the previous destination;
- the keep-or-clear rule for the upper 128 bits in 128-bit mode;
- the absence of faults in 256-bit mode.

Only the bench scenarios can show the lane arithmetic itself: the rounding, the wrap to 16'h8000 and lane placement. The bench sweeps every value of one operand against several fixed values of the other, covers a grid of corner pairs and runs random vectors. It also exercises the 64-bit upper-bit handling and the single-cycle length of each fault pulse.

// File: rtl/q15_rmul_pkg.sv
`timescale 1ns/1ps
package q15_rmul_pkg;

    typedef enum logic [1:0] {
        WSEL_64  = 2'b00,
        WSEL_128 = 2'b01,
        WSEL_256 = 2'b10,
        WSEL_ALT = 2'b11
    } wsel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_DONE   = 2'b01,
        ST_FLT_GP = 2'b10,
        ST_FLT_UD = 2'b11
    } st_e;

endpackage

// File: rtl/q15_rmul_lane.sv
`timescale 1ns/1ps
module q15_rmul_lane #(
    parameter int LANE_W = 16
) (
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    output logic [LANE_W-1:0] lane_y
);
    localparam int PROD_W = 2 * LANE_W;
    localparam int SHIFT  = LANE_W - 2;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] bumped;
    logic                     lane_unused;

    always_comb begin
        prod   = $signed(op_a) * $signed(op_b);
        scaled = prod >>> SHIFT;
        bumped = scaled + $signed({{(PROD_W-1){1'b0}}, 1'b1});
        lane_y = bumped[LANE_W:1];
    end

    // Bits outside the kept window are dropped on purpose (wrap, no saturation).
    assign lane_unused = ^{bumped[PROD_W-1:LANE_W+1], bumped[0]};

endmodule

// File: rtl/q15_rmul_fault.sv
`timescale 1ns/1ps
module q15_rmul_fault
    import q15_rmul_pkg::*;
#(
    parameter int ADDR_W    = 48,
    parameter int ALIGN_LSB = 4
) (
    input  logic [1:0]        width_sel,
    input  logic              new_style,
    input  logic              len_bit,
    input  logic              mem_src,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              gp_hit,
    output logic              ud_hit
);
    logic is_128;
    logic misaligned;
    logic addr_unused;

    always_comb begin
        is_128     = (width_sel == WSEL_128);
        misaligned = |mem_addr[ALIGN_LSB-1:0];
        gp_hit     = is_128 && mem_src && misaligned;
        ud_hit     = is_128 && new_style && len_bit;
    end

    assign addr_unused = ^mem_addr[ADDR_W-1:ALIGN_LSB];

endmodule

// File: rtl/q15_rmul_merge.sv
`timescale 1ns/1ps
module q15_rmul_merge
    import q15_rmul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int BASE_W = 64
) (
    input  logic [4*BASE_W-1:0] calc,
    input  logic [4*BASE_W-1:0] prev,
    input  logic [1:0]          width_sel,
    input  logic                zero_upper,
    output logic [4*BASE_W-1:0] merged
);
    localparam int MAX_W = 4 * BASE_W;
    localparam int LANES = MAX_W / LANE_W;
    localparam int CNT_W = $clog2(LANES) + 1;

    logic [CNT_W-1:0] n_active;

    always_comb begin
        unique case (width_sel)
            WSEL_64:  n_active = CNT_W'(BASE_W / LANE_W);
            WSEL_128: n_active = CNT_W'(2 * BASE_W / LANE_W);
            WSEL_256: n_active = CNT_W'(LANES);
            WSEL_ALT: n_active = CNT_W'(LANES);
            default:  n_active = CNT_W'(LANES);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_sel
        logic lane_on;
        assign lane_on = (CNT_W'(i) < n_active);
        assign merged[i*LANE_W +: LANE_W] =
            lane_on    ? calc[i*LANE_W +: LANE_W] :
            zero_upper ? '0 : prev[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/q15_rmul_unit.sv
`timescale 1ns/1ps
module q15_rmul_unit
    import q15_rmul_pkg::*;
#(
    parameter int LANE_W    = 16,
    parameter int BASE_W    = 64,
    parameter int ADDR_W    = 48,
    parameter int ALIGN_LSB = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          width_sel,
    input  logic                new_style,
    input  logic                mem_src,
    input  logic [ADDR_W-1:0]   mem_addr,
    input  logic                len_bit,
    input  logic [4*BASE_W-1:0] src_a,
    input  logic [4*BASE_W-1:0] src_b,
    input  logic [4*BASE_W-1:0] dest_prev,
    output logic [4*BASE_W-1:0] res_out,
    output logic                res_valid,
    output logic                fault_gp,
    output logic                fault_ud
);
    localparam int MAX_W = 4 * BASE_W;
    localparam int LANES = MAX_W / LANE_W;

    logic [MAX_W-1:0] lane_res;
    logic [MAX_W-1:0] merged;
    logic [MAX_W-1:0] res_q;
    logic             gp_hit;
    logic             ud_hit;
    st_e              state_q;
    st_e              state_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        q15_rmul_lane #(.LANE_W(LANE_W)) u_lane (
            .op_a   (src_a[i*LANE_W +: LANE_W]),
            .op_b   (src_b[i*LANE_W +: LANE_W]),
            .lane_y (lane_res[i*LANE_W +: LANE_W])
        );
    end

    q15_rmul_fault #(.ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)) u_fault (
        .width_sel (width_sel),
        .new_style (new_style),
        .len_bit   (len_bit),
        .mem_src   (mem_src),
        .mem_addr  (mem_addr),
        .gp_hit    (gp_hit),
        .ud_hit    (ud_hit)
    );

    q15_rmul_merge #(.LANE_W(LANE_W), .BASE_W(BASE_W)) u_merge (
        .calc       (lane_res),
        .prev       (dest_prev),
        .width_sel  (width_sel),
        .zero_upper (new_style),
        .merged     (merged)
    );

    // Next state: the undefined-opcode fault outranks the alignment fault.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FLT_GP, ST_FLT_UD: begin
                if (!in_valid)   state_d = ST_IDLE;
                else if (ud_hit) state_d = ST_FLT_UD;
                else if (gp_hit) state_d = ST_FLT_GP;
                else             state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result register: a faulted issue passes the old destination through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (in_valid) begin
            res_q <= (ud_hit || gp_hit) ? dest_prev : merged;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        res_valid = 1'b0;
        fault_gp  = 1'b0;
        fault_ud  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_DONE:   res_valid = 1'b1;
            ST_FLT_GP: begin res_valid = 1'b1; fault_gp = 1'b1; end
            ST_FLT_UD: begin res_valid = 1'b1; fault_ud = 1'b1; end
            default:   ;
        endcase
    end

    assign res_out = res_q;

endmodule

// File: rtl/q15_rmul_chk.sv
`timescale 1ns/1ps
module q15_rmul_chk #(
    parameter int BASE_W    = 64,
    parameter int ADDR_W    = 48,
    parameter int ALIGN_LSB = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          width_sel,
    input logic                new_style,
    input logic                mem_src,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic                len_bit,
    input logic [4*BASE_W-1:0] dest_prev,
    input logic [4*BASE_W-1:0] res_out,
    input logic                res_valid,
    input logic                fault_gp,
    input logic                fault_ud
);
    localparam int MAX_W = 4 * BASE_W;
    localparam int HALF  = 2 * BASE_W;

    logic w128, ud_c, gp_c, chk_unused;
    assign w128       = (width_sel == 2'b01);
    assign ud_c       = w128 && new_style && len_bit;
    assign gp_c       = w128 && mem_src && (mem_addr[ALIGN_LSB-1:0] != '0);
    assign chk_unused = ^mem_addr[ADDR_W-1:ALIGN_LSB];

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    assert_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_gp, fault_ud}));
    assert_fault_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp || fault_ud) |-> res_valid);
    assert_ud_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ud_c) |=> (fault_ud && res_out == $past(dest_prev)));
    assert_gp_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gp_c && !ud_c) |=> (fault_gp && res_out == $past(dest_prev)));
    assert_ud_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ud_c && gp_c) |=> (fault_ud && !fault_gp));
    assert_zero_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && w128 && new_style && !ud_c && !gp_c) |=> (res_out[MAX_W-1:HALF] == '0));
    assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && w128 && !new_style && !gp_c)
        |=> (res_out[MAX_W-1:HALF] == $past(dest_prev[MAX_W-1:HALF])));
    assert_no_fault_wide_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && width_sel[1]) |=> (!fault_gp && !fault_ud));

endmodule

bind q15_rmul_unit q15_rmul_chk #(
    .BASE_W(BASE_W), .ADDR_W(ADDR_W), .ALIGN_LSB(ALIGN_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
    .new_style(new_style), .mem_src(mem_src), .mem_addr(mem_addr),
    .len_bit(len_bit), .dest_prev(dest_prev), .res_out(res_out),
    .res_valid(res_valid), .fault_gp(fault_gp), .fault_ud(fault_ud)
);

// File: tb/q15_rmul_unit_tb.sv
`timescale 1ns/1ps
module q15_rmul_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   width_sel = 2'b00;
    logic         new_style = 1'b0;
    logic         mem_src = 1'b0;
    logic [47:0]  mem_addr = '0;
    logic         len_bit = 1'b0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [255:0] dest_prev = '0;
    logic [255:0] res_out;
    logic         res_valid, fault_gp, fault_ud;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    q15_rmul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_sel(width_sel),
        .new_style(new_style), .mem_src(mem_src), .mem_addr(mem_addr),
        .len_bit(len_bit), .src_a(src_a), .src_b(src_b), .dest_prev(dest_prev),
        .res_out(res_out), .res_valid(res_valid), .fault_gp(fault_gp),
        .fault_ud(fault_ud)
    );

    function automatic logic [15:0] ref_lane(input logic signed [15:0] a,
                                             input logic signed [15:0] b);
        int p;
        p = int'(a) * int'(b);
        p = (p >>> 14) + 1;
        return p[16:1];
    endfunction

    function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                           input logic [255:0] prev, input logic [1:0] ws,
                                           input logic zero_up);
        logic [255:0] r;
        int n;
        n = (ws == 2'b00) ? 4 : (ws == 2'b01) ? 8 : 16;
        for (int i = 0; i < 16; i++) begin
            if (i < n) r[i*16 +: 16] = ref_lane(a[i*16 +: 16], b[i*16 +: 16]);
            else       r[i*16 +: 16] = zero_up ? 16'h0 : prev[i*16 +: 16];
        end
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            v[i*32 +: 32] = {seed[15:0], seed[31:16]} ^ seed;
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [255:0] a, input logic [255:0] b, input logic [255:0] prev,
                         input logic [1:0] ws, input logic ns, input logic mem,
                         input logic [47:0] addr, input logic len);
        @(negedge clk);
        src_a = a; src_b = b; dest_prev = prev; width_sel = ws;
        new_style = ns; mem_src = mem; mem_addr = addr; len_bit = len;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [255:0] a, b, p;
        logic [15:0] corners [8];
        corners = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h4000, 16'hC000, 16'h2001};

        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset", {res_out, 2'b0}, '0);
        check("R10 reset flags", {253'b0, res_valid, fault_gp, fault_ud}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: valid not high before the first issue is registered
        @(negedge clk);
        src_a = '0; src_b = '0; width_sel = 2'b10; in_valid = 1'b1;
        check("R10 pre-edge", {255'b0, res_valid}, '0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 latency", {255'b0, res_valid}, 256'd1);
        @(negedge clk);
        check("R10 drop", {255'b0, res_valid}, '0);

        // R1: sweep all values of a against fixed b values, 256-bit mode
        foreach (corners[k]) begin
            if (k == 3 || k == 4 || k == 5 || k == 6) begin
                for (int v = 0; v < 4096; v++) begin
                    for (int l = 0; l < 16; l++) begin
                        a[l*16 +: 16] = 16'((v * 16) + l);
                        b[l*16 +: 16] = corners[k];
                    end
                    issue(a, b, '0, 2'b10, 1'b0, 1'b0, '0, 1'b0);
                    check("R1 sweep", res_out, model(a, b, '0, 2'b10, 1'b0));
                end
            end
        end

        // R3 and R1: corner grid of all 64 pairs, 16 pairs per vector
        for (int g = 0; g < 4; g++) begin
            for (int l = 0; l < 16; l++) begin
                a[l*16 +: 16] = corners[(g * 16 + l) / 8];
                b[l*16 +: 16] = corners[(g * 16 + l) % 8];
            end
            issue(a, b, '0, 2'b10, 1'b0, 1'b0, '0, 1'b0);
            check("R3 corner grid", res_out, model(a, b, '0, 2'b10, 1'b0));
        end

        // R3: -32768 * -32768 gives 8000, neighbours unaffected
        a = {16{16'h1234}}; b = {16{16'h4321}};
        a[5*16 +: 16] = 16'h8000; b[5*16 +: 16] = 16'h8000;
        issue(a, b, '0, 2'b10, 1'b0, 1'b0, '0, 1'b0);
        check("R3 wrap lane", {240'b0, res_out[5*16 +: 16]}, 256'h8000);
        check("R3 neighbours", res_out, model(a, b, '0, 2'b10, 1'b0));

        // R1/R2: random vectors in every width and style; R4/R5 upper handling
        for (int t = 0; t < 400; t++) begin
            logic [1:0] ws;
            logic ns;
            a = rnd256(); b = rnd256(); p = rnd256();
            ws = 2'(t % 4);
            ns = t[2];
            issue(a, b, p, ws, ns, 1'b0, '0, 1'b0);
            check(ns ? "R2 R5 random" : "R2 R4 random", res_out, model(a, b, p, ws, ns));
        end

        // R4: legacy 128 keeps upper; 64 keeps above 64
        a = rnd256(); b = rnd256(); p = rnd256();
        issue(a, b, p, 2'b01, 1'b0, 1'b0, '0, 1'b1);
        check("R4 legacy128 upper", {128'b0, res_out[255:128]}, {128'b0, p[255:128]});
        check("R11 legacy len ignored", {254'b0, fault_gp, fault_ud}, '0);
        issue(a, b, p, 2'b00, 1'b0, 1'b0, '0, 1'b0);
        check("R4 legacy64 upper", {64'b0, res_out[255:64]}, {64'b0, p[255:64]});

        // R5: new-style clears above active width
        issue(a, b, p, 2'b01, 1'b1, 1'b0, '0, 1'b0);
        check("R5 new128 upper", {128'b0, res_out[255:128]}, '0);
        issue(a, b, p, 2'b00, 1'b1, 1'b0, '0, 1'b0);
        check("R5 new64 upper", {64'b0, res_out[255:64]}, '0);

        // R6: misaligned memory 128 -> GP, old destination kept, one-cycle pulse (R9)
        issue(a, b, p, 2'b01, 1'b0, 1'b1, 48'h1008, 1'b0);
        check("R6 gp flag", {253'b0, res_valid, fault_gp, fault_ud}, 256'b110);
        check("R6 gp result", res_out, p);
        @(negedge clk);
        check("R9 gp pulse end", {253'b0, res_valid, fault_gp, fault_ud}, '0);

        // R11: aligned memory, register source, 256 and 64 width misaligned -> no fault
        issue(a, b, p, 2'b01, 1'b0, 1'b1, 48'h1010, 1'b0);
        check("R11 aligned", {253'b0, res_valid, fault_gp, fault_ud}, 256'b100);
        check("R11 aligned result", res_out, model(a, b, p, 2'b01, 1'b0));
        issue(a, b, p, 2'b01, 1'b0, 1'b0, 48'h1003, 1'b0);
        check("R11 register src", {253'b0, res_valid, fault_gp, fault_ud}, 256'b100);
        issue(a, b, p, 2'b10, 1'b1, 1'b1, 48'h1003, 1'b1);
        check("R11 wide misaligned", {253'b0, res_valid, fault_gp, fault_ud}, 256'b100);
        issue(a, b, p, 2'b00, 1'b0, 1'b1, 48'h0005, 1'b0);
        check("R11 narrow misaligned", {253'b0, res_valid, fault_gp, fault_ud}, 256'b100);

        // R7: new-style 128 with length bit -> UD
        issue(a, b, p, 2'b01, 1'b1, 1'b0, '0, 1'b1);
        check("R7 ud flag", {253'b0, res_valid, fault_gp, fault_ud}, 256'b101);
        check("R7 ud result", res_out, p);
        @(negedge clk);
        check("R9 ud pulse end", {253'b0, res_valid, fault_gp, fault_ud}, '0);

        // R8: both conditions -> UD only
        issue(a, b, p, 2'b01, 1'b1, 1'b1, 48'h0002, 1'b1);
        check("R8 priority", {253'b0, res_valid, fault_gp, fault_ud}, 256'b101);
        check("R8 result", res_out, p);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule